// File: doc/BRIEF.md
# Collision-Safe Readout Pass Generator

This block decides when a control-bus read of a buffer may go ahead without colliding with higher-priority traffic on the same RAM address lines. Trigger-accept and token-ring accesses arrive with no timing relationship to the bus read, and they always win. While the main sequencer waits in its read setup state, this block watches a set of activity markers. It waits until it has seen three consecutive clock periods in which every marker was quiet.

The block works on the falling edge of the clock, half a period away from the rising edge used by the main sequencer. A progress counter goes up by one for each quiet check. Any active marker sends the counter back to zero. The second quiet check is the capture instant. At that edge, the RAM read data is loaded into a holding register and a strobe is raised. The first and third quiet checks therefore guarantee a free address bus for one clock period before and after the capture.

A pass output goes high once the third quiet check completes. It then stays high until the bus transaction ends. When a read does not target the readout space, pass is high the whole time and no gating happens.

Top module: `rdout_pass_gen`

## Requirements
- R1: While `rst_n` is low, the progress count is zero, `pass_o` is low (with `readout_space_i` high), `cap_stb_o` is low and `hold_o` is all zeros.
- R2: All state changes on the falling edge of `clk`. With `setup_i`, `req_i` and `readout_space_i` high, the progress count goes up by one at each falling edge on which every marker is inactive. A marker is active when its bit of `marker_i` is 1 (default polarity).
- R3: If any marker is active at a falling edge before pass is set, the count returns to zero. Pass then needs three new consecutive quiet checks.
- R4: At the falling edge that completes the second consecutive quiet check, `hold_o` loads `ram_rdata_i`. `cap_stb_o` is high for exactly the one clock period that follows that edge.
- R5: `hold_o` changes only at a capture edge as described in R4; at every other edge it keeps its value, whatever `ram_rdata_i` does.
- R6: `pass_o` goes high at the falling edge that completes the third consecutive quiet check, one edge after the capture.
- R7: Once set, pass ignores the markers and stays high while `req_i` is high. It clears at the first falling edge at which `req_i` is low.
- R8: While `readout_space_i` is low, `pass_o` is high with no delay. No checks are counted and nothing is captured.
- R9: A falling edge with `setup_i` low clears the progress count, so partial progress is lost. Pass, once set, is not cleared by this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the block uses its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus transaction in flight (high from request until release) |
| setup_i | input | 1 | Main sequencer is in its read setup state |
| readout_space_i | input | 1 | Current read targets the protected buffer space |
| marker_i | input | NUM_MARK | Activity markers of the priority accesses |
| ram_rdata_i | input | DATA_W | RAM read data to be captured |
| pass_o | output | 1 | Readout may complete |
| cap_stb_o | output | 1 | One-period strobe after the capture edge |
| hold_o | output | DATA_W | Holding register with the captured data |

## Verification
The bench goes after the following corner cases:
- A marker that arrives right after the capture edge. A design that counted it as harmless would set pass on a window with no trailing guard. It would also have to recapture the data on the restart.
- A marker that arrives after pass is already set. A design without the sticky behaviour would drop pass in the middle of the transaction.
- Setup that is left and re-entered. A design that kept its count would pass too early.
- Each marker bit active on its own. This catches a reduction that misses one bit.
- A read outside the readout space. A design that gated it would stall the read, or would overwrite the holding register.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   // index of the check at which data is captured (middle of an odd window)
   function automatic int unsigned capture_index(input int unsigned n_checks);
      return (n_checks + 1) / 2;
   endfunction
endpackage

// File: rtl/rpg_idle_detect.sv
module rpg_idle_detect #(
   parameter int unsigned NUM_MARK   = 3,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic [NUM_MARK-1:0] marker_i,
   output logic                idle_o
);
   generate
      if (ACTIVE_LOW) begin : g_act_low
         assign idle_o = &marker_i;
      end else begin : g_act_high
         assign idle_o = ~|marker_i;
      end
   endgenerate
endmodule

// File: rtl/rpg_window_seq.sv
module rpg_window_seq
   import rpg_pkg::*;
#(
   parameter int unsigned N_CHECKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic enable_i,
   input  logic idle_i,
   output logic cap_hit_o,
   output logic cap_stb_o,
   output logic pass_o
);
   localparam int unsigned CNT_W = $clog2(N_CHECKS + 1);
   localparam int unsigned MID   = capture_index(N_CHECKS);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_CHECKS);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(MID);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             pass_q, stb_q;

   always_comb begin
      if (!enable_i)                cnt_nxt = '0;
      else if (cnt_q == CNT_FULL)   cnt_nxt = cnt_q;
      else if (!idle_i)             cnt_nxt = '0;
      else                          cnt_nxt = cnt_q + 1'b1;
   end

   assign cap_hit_o = (cnt_nxt == CNT_MID) && (cnt_q != CNT_MID);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pass_q <= 1'b0;
         stb_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         stb_q  <= cap_hit_o;
         if (!req_i)                     pass_q <= 1'b0;
         else if (cnt_nxt == CNT_FULL)   pass_q <= 1'b1;
      end
   end

   assign cap_stb_o = stb_q;
   assign pass_o    = pass_q;
endmodule

// File: rtl/rpg_hold_reg.sv
module rpg_hold_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/rdout_pass_gen.sv
module rdout_pass_gen #(
   parameter int unsigned NUM_MARK   = 3,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned N_CHECKS   = 3,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic                setup_i,
   input  logic                readout_space_i,
   input  logic [NUM_MARK-1:0] marker_i,
   input  logic [DATA_W-1:0]   ram_rdata_i,
   output logic                pass_o,
   output logic                cap_stb_o,
   output logic [DATA_W-1:0]   hold_o
);
   generate
      if (N_CHECKS < 3 || (N_CHECKS % 2) == 0) begin : g_bad_checks
         $error("N_CHECKS must be odd and at least 3");
      end
      if (NUM_MARK < 1 || DATA_W < 1) begin : g_bad_width
         $error("NUM_MARK and DATA_W must be at least 1");
      end
   endgenerate

   logic idle, enable, cap_hit, pass_q;

   assign enable = setup_i & readout_space_i;

   rpg_idle_detect #(.NUM_MARK(NUM_MARK), .ACTIVE_LOW(ACTIVE_LOW)) u_idle (
      .marker_i (marker_i),
      .idle_o   (idle)
   );

   rpg_window_seq #(.N_CHECKS(N_CHECKS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .enable_i  (enable),
      .idle_i    (idle),
      .cap_hit_o (cap_hit),
      .cap_stb_o (cap_stb_o),
      .pass_o    (pass_q)
   );

   rpg_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cap_hit),
      .d_i    (ram_rdata_i),
      .q_o    (hold_o)
   );

   assign pass_o = pass_q | ~readout_space_i;
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
   parameter int unsigned NUM_MARK   = 3,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned N_CHECKS   = 3,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_i,
   input logic                setup_i,
   input logic                readout_space_i,
   input logic [NUM_MARK-1:0] marker_i,
   input logic                pass_q,
   input logic                pass_o,
   input logic                cap_stb_o,
   input logic [DATA_W-1:0]   hold_o
);
   logic busy;
   assign busy = ACTIVE_LOW ? ~&marker_i : |marker_i;

   // R4: strobe lasts one period
   assert_stb_single_R4: assert property (@(negedge clk) disable iff (!rst_n)
      cap_stb_o |=> !cap_stb_o);

   // R5: holding register moves only together with the strobe
   assert_hold_stable_R5: assert property (@(negedge clk) disable iff (!rst_n)
      !$stable(hold_o) |-> cap_stb_o);

   // R3: an active marker blocks a capture at that edge
   assert_busy_no_cap_R3: assert property (@(negedge clk) disable iff (!rst_n)
      (busy && !pass_q) |=> !cap_stb_o);

   // R9: no capture at an edge outside setup
   assert_nosetup_no_cap_R9: assert property (@(negedge clk) disable iff (!rst_n)
      !setup_i |=> !cap_stb_o);

   // R7: pass is sticky while the request stays
   assert_pass_sticky_R7: assert property (@(negedge clk) disable iff (!rst_n)
      (pass_q && req_i) |=> pass_q);

   // R8: outside the readout space pass is high
   assert_nonreadout_pass_R8: assert property (@(negedge clk) disable iff (!rst_n)
      !readout_space_i |-> pass_o);

   generate
      if (N_CHECKS == 3) begin : g_three
         // R6: pass rises one edge after the capture edge
         assert_pass_after_cap_R6: assert property (@(negedge clk) disable iff (!rst_n)
            $rose(pass_q) |-> $past(cap_stb_o));
      end
   endgenerate
endmodule

bind rdout_pass_gen rpg_checker #(
   .NUM_MARK(NUM_MARK), .DATA_W(DATA_W), .N_CHECKS(N_CHECKS), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_i           (req_i),
   .setup_i         (setup_i),
   .readout_space_i (readout_space_i),
   .marker_i        (marker_i),
   .pass_q          (pass_q),
   .pass_o          (pass_o),
   .cap_stb_o       (cap_stb_o),
   .hold_o          (hold_o)
);

// File: tb/sim_rdout_pass_gen.sv
`timescale 1ns/1ps
module sim_rdout_pass_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0, setup_i = 1'b0, readout_space_i = 1'b1;
   logic [2:0]  marker_i = '0;
   logic [15:0] ram_rdata_i = '0;
   logic        pass_o, cap_stb_o;
   logic [15:0] hold_o;

   always #5 clk = ~clk;

   rdout_pass_gen u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .setup_i(setup_i),
      .readout_space_i(readout_space_i), .marker_i(marker_i),
      .ram_rdata_i(ram_rdata_i), .pass_o(pass_o), .cap_stb_o(cap_stb_o),
      .hold_o(hold_o)
   );

   typedef struct {
      logic        pass;
      logic        stb;
      logic [15:0] hold;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   // reference state, derived from the requirements
   int          m_cnt = 0;
   logic        m_pass = 1'b0;
   logic [15:0] m_hold = '0;

   task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic r, input logic rs, input logic [2:0] mk,
                       input logic [15:0] d, input string tag);
      exp_t e;
      logic stb_n;
      @(posedge clk); #1;
      setup_i = s; req_i = r; readout_space_i = rs; marker_i = mk; ram_rdata_i = d;
      stb_n = 1'b0;
      if (!s || !rs)        m_cnt = 0;
      else if (m_cnt == 3)  m_cnt = 3;
      else if (mk != 3'b0)  m_cnt = 0;
      else begin
         m_cnt = m_cnt + 1;
         if (m_cnt == 2) begin stb_n = 1'b1; m_hold = d; end
      end
      if (!r)               m_pass = 1'b0;
      else if (m_cnt == 3)  m_pass = 1'b1;
      e.pass = m_pass | ~rs;
      e.stb  = stb_n;
      e.hold = m_hold;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // monitor: compares at the rising edge, away from the falling active edge
   always @(posedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, "pass_o", 16'(pass_o), 16'(e.pass));
         check(e.tag, "cap_stb_o", 16'(cap_stb_o), 16'(e.stb));
         check(e.tag, "hold_o", hold_o, e.hold);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", "pass_o", 16'(pass_o), 16'h0);
      check("R1", "cap_stb_o", 16'(cap_stb_o), 16'h0);
      check("R1", "hold_o", hold_o, 16'h0);
      @(posedge clk); #1 rst_n = 1'b1;

      // clean window: R2, R4, R6, then late markers R7
      step(1, 1, 1, 3'b000, 16'h1111, "R2");
      step(1, 1, 1, 3'b000, 16'h2222, "R4");
      step(1, 1, 1, 3'b000, 16'h3333, "R6");
      step(1, 1, 1, 3'b111, 16'h4444, "R7");
      step(0, 1, 1, 3'b010, 16'h5555, "R7");
      step(0, 0, 1, 3'b000, 16'h6666, "R7");
      step(0, 0, 1, 3'b000, 16'h6767, "R5");

      // restarts on each marker bit: R3
      step(1, 1, 1, 3'b000, 16'hA001, "R2");
      step(1, 1, 1, 3'b001, 16'hA002, "R3");
      step(1, 1, 1, 3'b000, 16'hA003, "R3");
      step(1, 1, 1, 3'b000, 16'hA004, "R4");
      step(1, 1, 1, 3'b010, 16'hA005, "R3");
      step(1, 1, 1, 3'b000, 16'hA006, "R5");
      step(1, 1, 1, 3'b100, 16'hA007, "R3");
      step(1, 1, 1, 3'b000, 16'hA008, "R3");
      step(1, 1, 1, 3'b000, 16'hA009, "R4");
      step(1, 1, 1, 3'b000, 16'hA00A, "R6");
      step(0, 0, 1, 3'b000, 16'hA00B, "R7");

      // setup left mid-window: R9
      step(1, 1, 1, 3'b000, 16'hB001, "R9");
      step(1, 1, 1, 3'b000, 16'hB002, "R9");
      step(0, 1, 1, 3'b000, 16'hB003, "R9");
      step(1, 1, 1, 3'b000, 16'hB004, "R9");
      step(1, 1, 1, 3'b000, 16'hB005, "R9");
      step(1, 1, 1, 3'b000, 16'hB006, "R6");
      step(0, 0, 1, 3'b000, 16'hB007, "R7");

      // outside readout space: R8
      step(1, 1, 0, 3'b000, 16'hC001, "R8");
      step(1, 1, 0, 3'b000, 16'hC002, "R8");
      step(1, 1, 0, 3'b101, 16'hC003, "R8");
      step(1, 1, 1, 3'b000, 16'hC004, "R8");
      step(1, 1, 1, 3'b000, 16'hC005, "R4");
      step(0, 0, 1, 3'b000, 16'hC006, "R5");

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule